// File: doc/BRIEF.md
# Shared-Interrupt Affinity Routing Bank

This block holds one 64-bit routing register for every shared interrupt of an interrupt distributor. Software writes an affinity value into the register of an interrupt. The block keeps the low three affinity levels, 24 bits in total. On the same write it resolves that value to a core index by comparing it with a per-core affinity table. The table is a parameter, 24 bits per core, with core 0 in the least significant bits. When several cores carry the same affinity, the lowest core index wins.

The register window is byte addressed, and the interrupt ID is the address divided by 8. The first 32 IDs are private interrupts, so their registers are inert. IDs past the implemented shared range are inert as well. A register slot is 8 bytes, but only its lower word holds state; the upper word is inert.

A second, read-only port lets the pending logic ask for the target of any interrupt ID. It returns the resolved core index and a valid flag, with no wait cycles. Register reads are also combinational. Writes take effect at the next rising clock edge.

Top module: `irq_route_bank`

## Requirements
- R1: After reset every stored affinity is zero. A lookup of any implemented shared ID reports the core whose table entry is zero, with valid set.
- R2: The register of interrupt ID n sits at byte address 8*n. Shared IDs run from 32 up to 32+NUM_SPI-1, and the last one is fully writable and readable.
- R3: A write keeps only write-data bits 23:0. Every other write-data bit is discarded and reads back as zero.
- R4: A 32-bit access (size input 0) with address bit 2 set reads as zero and leaves all stored state unchanged when written.
- R5: Registers of IDs 0 to 31 read as zero and ignore writes, and a lookup of those IDs returns valid low.
- R6: Registers of IDs at or above 32+NUM_SPI read as zero and ignore writes, and a lookup of those IDs returns valid low.
- R7: A 64-bit access (size input 1) ignores address bit 2 and reaches the lower word. Every read returns the affinity in bits 23:0 with bits 63:24 zero.
- R8: From the cycle after a write, a lookup of that ID returns the index of the core whose table entry equals the stored affinity, with valid set.
- R9: When no table entry equals the stored affinity, the lookup valid flag of that ID is low. A later write with a matching affinity sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address inside the routing window |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| sz64 | input | 1 | Access size: 1 for 64-bit, 0 for 32-bit |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Combinational read data for `addr` |
| lk_id | input | ADDR_W-3 | Interrupt ID to look up |
| lk_core | output | CORE_W | Resolved target core index |
| lk_valid | output | 1 | Set when the looked-up ID targets a core |

## Verification
Affinity writes are aimed at each core-table entry in turn, including entries that differ only in level 1 or only in level 2. This shows that all three levels take part in the match. A value that matches no entry is written as well, which separates a cleared valid flag from a stale core index.

Writes are also sent with all-ones junk in the discarded bits, to the upper word, to private IDs and to IDs past the implemented range. Each such write is followed by a read of the shared slot that a truncated index would alias to. This separates a correct region decode from one that wraps around.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int AFF_W  = 24;
  localparam int DATA_W = 64;
  localparam int PRIV_IDS = 32;
  typedef logic [AFF_W-1:0] aff_t;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int ADDR_W  = 13,
  localparam int ID_W   = ADDR_W - 3,
  localparam int IDX_W  = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sz64_i,
  output logic              inrange_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ID_W:0] FIRST_ID = (ID_W+1)'(PRIV_IDS);
  localparam logic [ID_W:0] END_ID   = (ID_W+1)'(PRIV_IDS + NUM_SPI);

  logic [ID_W-1:0] id;
  logic [ID_W-1:0] rel;
  logic            upper;

  always_comb begin
    id        = addr_i[ADDR_W-1:3];
    upper     = !sz64_i && addr_i[2];
    inrange_o = ({1'b0, id} >= FIRST_ID) && ({1'b0, id} < END_ID);
    hit_o     = inrange_o && !upper;
    rel       = id - FIRST_ID[ID_W-1:0];
    idx_o     = rel[IDX_W-1:0];
  end

  // R4: a 32-bit access to the upper word never reaches storage
  assert_upper_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sz64_i && addr_i[2]) |-> !hit_o);

  // R5: private IDs are never decoded as shared
  assert_private_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[ADDR_W-1:3] < ID_W'(PRIV_IDS)) |-> !inrange_o);
endmodule

// File: rtl/irq_route_match.sv
module irq_route_match
  import irq_route_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter logic [NUM_CORES*24-1:0] CORE_AFF = '0,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  aff_t              aff_i,
  output logic [CORE_W-1:0] core_o,
  output logic              hit_o
);
  logic [NUM_CORES-1:0] eq;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_cmp
    assign eq[c] = (CORE_AFF[c*AFF_W +: AFF_W] == aff_i);
  end

  // lowest matching core index wins
  always_comb begin
    core_o = '0;
    hit_o  = 1'b0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (eq[c]) begin
        core_o = CORE_W'(c);
        hit_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SPI   = 32,
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 13,
  parameter logic [NUM_CORES*24-1:0] CORE_AFF =
    {24'h010000, 24'h000100, 24'h000001, 24'h000000},
  localparam int ID_W   = ADDR_W - 3,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              sz64,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  input  logic [ID_W-1:0]   lk_id,
  output logic [CORE_W-1:0] lk_core,
  output logic              lk_valid
);
  localparam int IDX_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;

  aff_t        [NUM_SPI-1:0] aff_q;
  logic        [NUM_SPI-1:0] val_q;
  logic [NUM_SPI-1:0][CORE_W-1:0] core_q;

  logic             acc_inrange, acc_hit;
  logic [IDX_W-1:0] acc_idx;
  logic             lk_inrange, lk_hit_unused;
  logic [IDX_W-1:0] lk_idx;

  aff_t              aff_d;
  logic [CORE_W-1:0] core_d, core_rst;
  logic              val_d, val_rst;
  logic              wr_go;

  // register access decode
  irq_route_decode #(.NUM_SPI(NUM_SPI), .ADDR_W(ADDR_W)) u_acc_dec (
    .clk(clk), .rst_n(rst_n),
    .addr_i(addr), .sz64_i(sz64),
    .inrange_o(acc_inrange), .hit_o(acc_hit), .idx_o(acc_idx)
  );

  // lookup decode, same range rules
  irq_route_decode #(.NUM_SPI(NUM_SPI), .ADDR_W(ADDR_W)) u_lk_dec (
    .clk(clk), .rst_n(rst_n),
    .addr_i({lk_id, 3'b000}), .sz64_i(1'b1),
    .inrange_o(lk_inrange), .hit_o(lk_hit_unused), .idx_o(lk_idx)
  );

  // resolve the incoming affinity
  irq_route_match #(.NUM_CORES(NUM_CORES), .CORE_AFF(CORE_AFF)) u_wr_match (
    .aff_i(aff_d), .core_o(core_d), .hit_o(val_d)
  );

  // resolve the reset affinity (zero)
  irq_route_match #(.NUM_CORES(NUM_CORES), .CORE_AFF(CORE_AFF)) u_rst_match (
    .aff_i('0), .core_o(core_rst), .hit_o(val_rst)
  );

  // next state
  always_comb begin
    aff_d = wdata[AFF_W-1:0];
    wr_go = wr_en && acc_hit;
  end

  // state registers with write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SPI; i++) begin
        aff_q[i]  <= '0;
        core_q[i] <= core_rst;
        val_q[i]  <= val_rst;
      end
    end else if (wr_go) begin
      aff_q[acc_idx]  <= aff_d;
      core_q[acc_idx] <= core_d;
      val_q[acc_idx]  <= val_d;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    if (acc_hit) rdata[AFF_W-1:0] = aff_q[acc_idx];
  end

  // lookup path
  always_comb begin
    lk_core  = '0;
    lk_valid = 1'b0;
    if (lk_inrange) begin
      lk_core  = core_q[lk_idx];
      lk_valid = val_q[lk_idx];
    end
  end

  // R4/R5/R6: a write that misses the shared lower words changes nothing
  assert_miss_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_hit) |=> $stable(aff_q));

  // R3: a decoded write stores exactly the low 24 data bits
  assert_store_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_hit) |=> aff_q[$past(acc_idx)] == $past(wdata[AFF_W-1:0]));

  // R8: a valid lookup names a core whose table entry equals the stored affinity
  assert_route_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (CORE_AFF[lk_core*AFF_W +: AFF_W] == aff_q[lk_idx]));

  // R6: IDs outside the shared range never report a target
  assert_lk_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_inrange |-> !lk_valid);

  // R7: bits above the affinity always read zero
  assert_rdata_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_inrange |-> (rdata[63:AFF_W] == '0));
endmodule

// File: tb/irq_route_bank_bench.sv
module irq_route_bank_bench;
  localparam int ADDR_W = 13;
  localparam int ID_W   = ADDR_W - 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic              sz64;
  logic [63:0]       wdata;
  logic [63:0]       rdata;
  logic [ID_W-1:0]   lk_id;
  logic [1:0]        lk_core;
  logic              lk_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_route_bank u_irq_route_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .sz64(sz64),
    .wdata(wdata), .rdata(rdata), .lk_id(lk_id), .lk_core(lk_core),
    .lk_valid(lk_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int id, input bit upper, input bit s64, input logic [63:0] d);
    @(negedge clk);
    addr  = ADDR_W'(id * 8 + (upper ? 4 : 0));
    sz64  = s64;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wdata = '0;
  endtask

  task automatic rd(input int id, input bit upper, input bit s64, output logic [63:0] d);
    @(negedge clk);
    addr = ADDR_W'(id * 8 + (upper ? 4 : 0));
    sz64 = s64;
    #2;
    d = rdata;
  endtask

  task automatic look(input int id, output logic [1:0] c, output logic v);
    @(negedge clk);
    lk_id = ID_W'(id);
    #2;
    c = lk_core;
    v = lk_valid;
  endtask

  task automatic t_reset;
    logic [63:0] d; logic [1:0] c; logic v;
    rd(32, 0, 1, d); check("R1 reset affinity id32", d, 64'h0);
    look(32, c, v); check("R1 reset target id32", {v, c}, {1'b1, 2'd0});
    look(63, c, v); check("R1 reset target id63", {v, c}, {1'b1, 2'd0});
  endtask

  task automatic t_wide_write;
    logic [63:0] d; logic [1:0] c; logic v;
    wr(40, 0, 1, 64'hFFFF_FFFF_FF00_0100);
    rd(40, 0, 1, d); check("R3 R7 64-bit read keeps 23:0 only", d, 64'h0000_0100);
    look(40, c, v); check("R8 level1 match core2", {v, c}, {1'b1, 2'd2});
  endtask

  task automatic t_narrow_write;
    logic [63:0] d; logic [1:0] c; logic v;
    wr(33, 0, 0, 64'h0000_0000_AB01_0000);
    rd(33, 0, 0, d); check("R3 32-bit lower write", d, 64'h0001_0000);
    look(33, c, v); check("R8 level2 match core3", {v, c}, {1'b1, 2'd3});
  endtask

  task automatic t_upper_word;
    logic [63:0] d;
    wr(33, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(33, 0, 0, d); check("R4 upper write ignored", d, 64'h0001_0000);
    rd(33, 1, 0, d); check("R4 upper word reads zero", d, 64'h0);
  endtask

  task automatic t_wide_bit2;
    logic [63:0] d; logic [1:0] c; logic v;
    wr(33, 1, 1, 64'h0000_0000_0000_0001);
    rd(33, 1, 1, d); check("R7 64-bit ignores bit2", d, 64'h1);
    look(33, c, v); check("R8 level0 match core1", {v, c}, {1'b1, 2'd1});
  endtask

  task automatic t_private;
    logic [63:0] d; logic [1:0] c; logic v;
    wr(5, 0, 1, 64'h0000_0000_0000_0100);
    rd(5, 0, 1, d); check("R5 private reads zero", d, 64'h0);
    rd(37, 0, 1, d); check("R5 private write no alias id37", d, 64'h0);
    look(5, c, v); check("R5 private lookup invalid", {63'h0, v}, 64'h0);
  endtask

  task automatic t_out_of_range;
    logic [63:0] d; logic [1:0] c; logic v;
    wr(64, 0, 1, 64'h0000_0000_0001_0000);
    rd(64, 0, 1, d); check("R6 beyond range reads zero", d, 64'h0);
    rd(32, 0, 1, d); check("R6 no alias into id32", d, 64'h0);
    look(64, c, v); check("R6 beyond range lookup invalid", {63'h0, v}, 64'h0);
  endtask

  task automatic t_no_match;
    logic [1:0] c; logic v;
    wr(50, 0, 1, 64'h0000_0000_0012_3456);
    look(50, c, v); check("R9 no match clears valid", {63'h0, v}, 64'h0);
    wr(50, 0, 0, 64'h0000_0000_0000_0100);
    look(50, c, v); check("R9 rematch restores valid", {v, c}, {1'b1, 2'd2});
  endtask

  task automatic t_last_id;
    logic [63:0] d; logic [1:0] c; logic v;
    wr(63, 0, 0, 64'h0000_0000_0001_0000);
    rd(63, 0, 0, d); check("R2 last shared id stores", d, 64'h0001_0000);
    look(63, c, v); check("R2 last shared id routes", {v, c}, {1'b1, 2'd3});
    rd(62, 0, 0, d); check("R2 neighbour id62 untouched", d, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; sz64 = 1'b0; wdata = '0; lk_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_wide_write();
    t_narrow_write();
    t_upper_word();
    t_wide_bit2();
    t_private();
    t_out_of_range();
    t_no_match();
    t_last_id();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule